// File: doc/BRIEF.md
# SDRAM Power-Up and Access Sequencer

This block drives the command pins of one rank of four-bank SDR SDRAM. Out of reset it walks the device through its start-up procedure: a long stretch of NOPs, a precharge of all banks, two auto-refresh cycles and a mode-register load. After that it serves one burst at a time for a host that offers a request strobe, a read/write flag, an auto-precharge flag and a flat address.

The flat address splits into bank (top bits), row (middle) and column (bottom bits). Each access opens the row, issues the column command and then closes the row. The row closes either through the device's own auto-precharge or through an explicit single-bank precharge. Every wait is a cycle count derived at elaboration from a clock-frequency parameter and nanosecond timing parameters. The count rounds up and is at least one cycle. Empty cycles carry NOP.

Top module: `sdr_cmd_sequencer`

## Requirements
- R1: All command and address outputs come from registers. While reset is held, the block drives INHIBIT (`{cs_n,ras_n,cas_n,we_n}`=1111), `ready`=0, and BA and A as zero. Encodings: NOP 0111, ACTIVE 0011, READ 0101, WRITE 0100, PRECHARGE 0010, AUTO REFRESH 0001, LOAD MODE 0000.
- R2: After reset release, the first INIT_US*CLK_MHZ rising edges carry only NOP. Whenever NOP is driven, BA and A are zero.
- R3: On the next edge after that wait, the block issues PRECHARGE with A10=1 (all banks). BA and the other A bits are zero.
- R4: Exactly two AUTO REFRESH commands follow. The first comes tRP cycles after the precharge and the second comes tRFC cycles after the first.
- R5: LOAD MODE is issued tRFC cycles after the second refresh, with BA=0. A[2:0] carries the burst-length code (1→0, 2→1, 4→2, 8→3, full page→7). A[6:4] carries the CAS latency. All other A bits are zero. With the default parameters A=0x032.
- R6: `ready` stays low until tMRD cycles after LOAD MODE and then goes high. Requests made before that point produce no command.
- R7: When `req` is sampled high while `ready` is high, ACTIVE is issued on that edge and `ready` falls. The flat address is split so that BA = address[24:23] and A = address[22:10].
- R8: READ (`req_we`=0) or WRITE (`req_we`=1) follows ACTIVE by tRCD cycles. It carries the same BA, the column (address[9:0]) on A[9:0], the auto-precharge flag on A10, and A[12:11]=0.
- R9: When auto-precharge is requested, no further command follows the READ/WRITE, and `ready` returns burst-length + tRP cycles after it.
- R10: Without auto-precharge, a single-bank PRECHARGE follows the READ/WRITE by burst-length cycles, with A10=0, A otherwise zero and the same BA. `ready` returns tRP cycles after that precharge. A full-page burst always takes this path.
- R11: A request held high while the block is busy is ignored until the block is idle. The block then accepts it on the first edge of the idle state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | 1 | Access request strobe |
| req_we | input | 1 | 1 = write, 0 = read |
| req_ap | input | 1 | 1 = close the row with auto-precharge |
| req_addr | input | 25 | Flat address {bank, row, column} |
| ready | output | 1 | Block is idle and can accept a request |
| sd_cs_n | output | 1 | Chip select, active low |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_ba | output | 2 | Bank address |
| sd_a | output | 13 | Row, column or mode word |

## Verification
The full command bus is compared against a schedule that the bench builds from the timing parameters, on every cycle from reset release through initialization and several accesses. The access mix is as follows:
- A read with auto-precharge and a mid-range address. This separates the ACTIVE/READ split from the closing path.
- A write without auto-precharge at the all-ones bank, row and column. This exposes field truncation and the A10 role in the explicit single-bank precharge.
- A request held high across a busy period. This shows whether a busy block leaks an extra ACTIVE and whether it accepts on the very first idle edge.

Requests pulsed during the power-up wait show whether anything can preempt initialization.

// File: rtl/sdr_cmd_sequencer.sv
module sdr_cmd_sequencer #(
  parameter int CLK_MHZ   = 200,
  parameter int INIT_US   = 100,
  parameter int TRP_NS    = 20,
  parameter int TRFC_NS   = 66,
  parameter int TRCD_NS   = 20,
  parameter int TMRD_CK   = 2,
  parameter int CAS_LAT   = 3,
  parameter int BURST_LEN = 4,
  parameter int BANK_W    = 2,
  parameter int ROW_W     = 13,
  parameter int COL_W     = 10
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            req,
  input  logic                            req_we,
  input  logic                            req_ap,
  input  logic [BANK_W+ROW_W+COL_W-1:0]   req_addr,
  output logic                            ready,
  output logic                            sd_cs_n,
  output logic                            sd_ras_n,
  output logic                            sd_cas_n,
  output logic                            sd_we_n,
  output logic [BANK_W-1:0]               sd_ba,
  output logic [ROW_W-1:0]                sd_a
);
  function automatic int ns2cyc(int ns);
    int c;
    c = (ns * CLK_MHZ + 999) / 1000;
    return (c < 1) ? 1 : c;
  endfunction

  localparam int ADDR_W   = BANK_W + ROW_W + COL_W;
  localparam int INIT_CYC = INIT_US * CLK_MHZ;
  localparam int TRP_C    = ns2cyc(TRP_NS);
  localparam int TRFC_C   = ns2cyc(TRFC_NS);
  localparam int TRCD_C   = ns2cyc(TRCD_NS);
  localparam int TMRD_C   = (TMRD_CK < 1) ? 1 : TMRD_CK;
  localparam bit FULLPG   = (BURST_LEN == 0);
  localparam int BL_CYC   = FULLPG ? (1 << COL_W) : BURST_LEN;
  localparam int CNT_W    = $clog2(INIT_CYC + BL_CYC + TRP_C + TRFC_C + TRCD_C + 2);
  localparam logic [2:0] BL_CODE = FULLPG ? 3'd7 : (BURST_LEN == 8) ? 3'd3 :
                                   (BURST_LEN == 4) ? 3'd2 : (BURST_LEN == 2) ? 3'd1 : 3'd0;
  localparam logic [ROW_W-1:0] MODE_WORD = ROW_W'({3'(CAS_LAT), 1'b0, BL_CODE});

  localparam logic [3:0] CMD_INH = 4'b1111, CMD_NOP = 4'b0111, CMD_ACT = 4'b0011,
                         CMD_RD  = 4'b0101, CMD_WR  = 4'b0100, CMD_PRE = 4'b0010,
                         CMD_REF = 4'b0001, CMD_LMR = 4'b0000;

  typedef enum logic [3:0] {
    S_PWR, S_PREALL, S_REF1, S_REF2, S_MRD, S_IDLE, S_RCD, S_BURST, S_TAIL
  } state_t;

  state_t                st;
  logic [CNT_W-1:0]      cnt;
  logic [3:0]            cmd;
  logic [BANK_W-1:0]     bank_q;
  logic [COL_W-1:0]      col_q;
  logic                  we_q, ap_q;
  logic [ROW_W-1:0]      col_word;

  assign col_word = ROW_W'(col_q) | (ROW_W'(ap_q) << 10);
  assign ready = (st == S_IDLE);
  assign {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} = cmd;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_PWR;
      cnt    <= CNT_W'(INIT_CYC);
      cmd    <= CMD_INH;
      sd_ba  <= '0;
      sd_a   <= '0;
      bank_q <= '0;
      col_q  <= '0;
      we_q   <= 1'b0;
      ap_q   <= 1'b0;
    end else begin
      cmd   <= CMD_NOP;
      sd_ba <= '0;
      sd_a  <= '0;
      if (cnt != '0) cnt <= cnt - CNT_W'(1);
      case (st)
        S_PWR: if (cnt == '0) begin
          cmd <= CMD_PRE; sd_a <= ROW_W'(1) << 10;
          cnt <= CNT_W'(TRP_C - 1); st <= S_PREALL;
        end
        S_PREALL: if (cnt == '0) begin
          cmd <= CMD_REF; cnt <= CNT_W'(TRFC_C - 1); st <= S_REF1;
        end
        S_REF1: if (cnt == '0) begin
          cmd <= CMD_REF; cnt <= CNT_W'(TRFC_C - 1); st <= S_REF2;
        end
        S_REF2: if (cnt == '0) begin
          cmd <= CMD_LMR; sd_a <= MODE_WORD;
          cnt <= CNT_W'(TMRD_C - 1); st <= S_MRD;
        end
        S_MRD: if (cnt == '0) st <= S_IDLE;
        S_IDLE: if (req) begin
          cmd    <= CMD_ACT;
          sd_ba  <= req_addr[ADDR_W-1 -: BANK_W];
          sd_a   <= req_addr[COL_W +: ROW_W];
          bank_q <= req_addr[ADDR_W-1 -: BANK_W];
          col_q  <= req_addr[COL_W-1:0];
          we_q   <= req_we;
          ap_q   <= req_ap && !FULLPG;
          cnt    <= CNT_W'(TRCD_C - 1);
          st     <= S_RCD;
        end
        S_RCD: if (cnt == '0) begin
          cmd   <= we_q ? CMD_WR : CMD_RD;
          sd_ba <= bank_q;
          sd_a  <= col_word;
          if (ap_q) begin
            cnt <= CNT_W'(BL_CYC + TRP_C - 1); st <= S_TAIL;
          end else begin
            cnt <= CNT_W'(BL_CYC - 1); st <= S_BURST;
          end
        end
        S_BURST: if (cnt == '0) begin
          cmd <= CMD_PRE; sd_ba <= bank_q;
          cnt <= CNT_W'(TRP_C - 1); st <= S_TAIL;
        end
        S_TAIL: if (cnt == '0) st <= S_IDLE;
        default: st <= S_PWR;
      endcase
    end
  end

  logic       lmr_seen;
  logic [1:0] ref_seen;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lmr_seen <= 1'b0;
      ref_seen <= 2'd0;
    end else begin
      if (cmd == CMD_LMR) lmr_seen <= 1'b1;
      if (cmd == CMD_REF && ref_seen != 2'd3) ref_seen <= ref_seen + 2'd1;
    end
  end

  AST_ACT_ONLY_ON_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == CMD_ACT) |-> ($past(ready) && $past(req))); // R7
  AST_NO_ACCESS_BEFORE_MODE: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == CMD_ACT || cmd == CMD_RD || cmd == CMD_WR) |-> lmr_seen); // R6
  AST_TWO_REFRESH_BEFORE_MODE: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == CMD_LMR) |-> (ref_seen == 2'd2)); // R4
  AST_INIT_PRE_ALL_BANKS: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == CMD_PRE && !lmr_seen) |-> sd_a[10]); // R3
  AST_IDLE_BUS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    ready |-> (cmd == CMD_NOP && sd_ba == '0 && sd_a == '0)); // R2
endmodule

// File: tb/sdr_cmd_sequencer_tb.sv
`timescale 1ns/1ps
module sdr_cmd_sequencer_tb;
  localparam int INIT = 100 * 200;
  localparam int TRP  = 4;
  localparam int TRFC = 14;
  localparam int TRCD = 4;
  localparam int TMRD = 2;
  localparam int BL   = 4;
  localparam logic [3:0] NOP = 4'b0111, ACT = 4'b0011, RD = 4'b0101, WR = 4'b0100,
                         PRE = 4'b0010, REF = 4'b0001, LMR = 4'b0000;

  logic clk = 1'b0, rst_n = 1'b0, req = 1'b0, req_we = 1'b0, req_ap = 1'b0;
  logic [24:0] req_addr = '0;
  logic ready, cs_n, ras_n, cas_n, we_n;
  logic [1:0] ba;
  logic [12:0] a;

  sdr_cmd_sequencer #(.CLK_MHZ(200), .INIT_US(100), .TRP_NS(20), .TRFC_NS(66),
    .TRCD_NS(20), .TMRD_CK(2), .CAS_LAT(3), .BURST_LEN(4)) u_dut (
    .clk(clk), .rst_n(rst_n), .req(req), .req_we(req_we), .req_ap(req_ap),
    .req_addr(req_addr), .ready(ready), .sd_cs_n(cs_n), .sd_ras_n(ras_n),
    .sd_cas_n(cas_n), .sd_we_n(we_n), .sd_ba(ba), .sd_a(a));

  always #2.5 clk = ~clk;

  int n_chk = 0, n_fail = 0, cyc = 0, idle_at = 0;
  bit done = 1'b0;
  string rtag = "R6";
  logic [18:0] exp_cmd[int];
  string exp_tag[int];

  task automatic chk(bit ok, string tag, logic [31:0] got, logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s cycle %0d: got %0h expected %0h", tag, cyc, got, exp);
    end
  endtask

  task automatic sched(int at, logic [3:0] c, logic [1:0] b, logic [12:0] ad, string tag);
    exp_cmd[at] = {c, b, ad};
    exp_tag[at] = tag;
  endtask

  always @(posedge clk) if (rst_n) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (rst_n && cyc > 0 && !done) begin
      logic [18:0] e;
      string t;
      e = exp_cmd.exists(cyc) ? exp_cmd[cyc] : {NOP, 2'b0, 13'b0};
      t = exp_tag.exists(cyc) ? exp_tag[cyc] : ((cyc <= INIT) ? "R2" : "R11");
      chk({cs_n, ras_n, cas_n, we_n, ba, a} === e, t,
          32'({cs_n, ras_n, cas_n, we_n, ba, a}), 32'(e));
      chk(ready === (cyc >= idle_at), rtag, 32'(ready), 32'(cyc >= idle_at));
    end
  end

  task automatic access(bit we, bit ap, logic [1:0] b, logic [12:0] row,
                        logic [9:0] col, bit keep);
    int acc, rw;
    forever begin
      @(negedge clk); #1;
      if (cyc >= idle_at) break;
    end
    req = 1'b1; req_we = we; req_ap = ap; req_addr = {b, row, col};
    acc = cyc + 1;
    rw  = acc + TRCD;
    sched(acc, ACT, b, row, "R7");
    sched(rw, we ? WR : RD, b, {2'b00, ap, col}, "R8");
    if (ap) begin
      idle_at = rw + BL + TRP;
      rtag = "R9";
    end else begin
      sched(rw + BL, PRE, b, 13'h0, "R10");
      idle_at = rw + BL + TRP;
      rtag = "R10";
    end
    @(negedge clk); #1;
    if (!keep) req = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk({cs_n, ras_n, cas_n, we_n} === 4'b1111, "R1", 32'({cs_n, ras_n, cas_n, we_n}), 32'hF);
    chk(ready === 1'b0, "R1", 32'(ready), 32'h0);
    chk({ba, a} === 15'h0, "R1", 32'({ba, a}), 32'h0);
    sched(INIT + 1, PRE, 2'b0, 13'h0400, "R3");
    sched(INIT + 1 + TRP, REF, 2'b0, 13'h0, "R4");
    sched(INIT + 1 + TRP + TRFC, REF, 2'b0, 13'h0, "R4");
    sched(INIT + 1 + TRP + 2 * TRFC, LMR, 2'b0, 13'h032, "R5");
    idle_at = INIT + 1 + TRP + 2 * TRFC + TMRD;
    #1 rst_n = 1'b1;
    repeat (100) @(negedge clk);
    #1 req = 1'b1; req_addr = {2'd2, 13'h0123, 10'h045};
    repeat (30) @(negedge clk);
    #1 req = 1'b0;
    access(1'b0, 1'b1, 2'd1, 13'h1ABC, 10'h155, 1'b0);
    access(1'b1, 1'b0, 2'd3, 13'h1FFF, 10'h3FF, 1'b0);
    access(1'b1, 1'b1, 2'd0, 13'h0000, 10'h000, 1'b1);
    access(1'b0, 1'b0, 2'd2, 13'h0AA5, 10'h2C3, 1'b0);
    forever begin
      @(negedge clk); #1;
      if (cyc >= idle_at + 8) break;
    end
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(5.0 * 60000);
    done = 1'b1;
    n_chk++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule